// File: doc/BRIEF.md
# Packed Integer Lane ALU (add, minimum, compare mask)

This block performs one integer operation per transaction on a 64-bit word that is split into equal lanes of 8, 16, 32 or 64 bits. The supported operations are a lane-wise add, a lane-wise minimum, and a lane-wise compare that produces a mask. The add can wrap, saturate as unsigned or saturate as signed. The minimum can treat lanes as unsigned or as signed. The compare tests either equality or signed greater-than, and each lane of its result is all ones or all zeros.

Three modifier bits go with each request. The first bit selects scalar mode. In scalar mode only the lowest lane is computed, and every other lane returns the caller's previous destination word unchanged. For this reason the previous destination is an input of the unit. The result is held in a register and appears one cycle after the request, together with a valid flag.

Top module: `packed_lane_alu`

## Requirements
- R1: The opcode is 2 bits: 0 selects add, 1 selects minimum, 2 selects compare. Code 3 is reserved, and its result equals the previous-destination input bit for bit.
- R2: The size code is 2 bits: 0, 1, 2 and 3 give lanes of 8, 16, 32 and 64 bits. Lane 0 occupies the least significant bits. No carry or other effect crosses a lane boundary.
- R3: An add with modifier bits 1 and 2 both clear wraps each lane sum modulo 2 to the power of the lane width.
- R4: An add with modifier bit 1 set saturates as unsigned: a lane whose sum carries out becomes all ones. Bit 1 takes precedence over bit 2.
- R5: An add with bit 1 clear and bit 2 set saturates as signed. A lane overflows when both operands have the same sign and the wrapped sum has the other sign. An overflowed lane becomes the most negative value if the wrapped sum is non-negative, and the most positive value otherwise.
- R6: Minimum writes, per lane, the smaller operand's bits. Bit 1 set compares the lanes as two's-complement values, and bit 1 clear compares them as unsigned values. On equality the second operand is written.
- R7: Compare with bit 1 clear sets a lane to all ones when the two lanes are equal. With bit 1 set it sets a lane to all ones when the first operand is greater than the second as a signed value. Every other lane becomes zero.
- R8: Modifier bit 0 set (scalar mode) computes lane 0 only. All higher lanes of the result equal the previous-destination input.
- R9: When the valid input is high at a clock edge, the output valid is high after that edge and the result holds the computed value. When the valid input is low, the output valid goes low and the result keeps its earlier value. A synchronous active-high reset clears the output valid and the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 2 | Operation code (R1) |
| in_size | input | 2 | Lane size code (R2) |
| in_ext | input | 3 | Modifier bits: 0 scalar, 1 and 2 as per operation |
| in_src_a | input | 64 | First operand |
| in_src_b | input | 64 | Second operand |
| in_old | input | 64 | Previous destination word |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_result | output | 64 | Registered result |

## Verification
The embedded assertions check several properties on every cycle. They check the one-cycle valid timing and the hold when no request is present. They check that a reserved opcode returns the previous destination, and that scalar requests on narrow lanes keep the upper half of the previous destination. They also check that a full-width compare gives an all-ones or all-zeros word, and that an unsigned-saturating full-width add never returns less than its first operand. Other behaviours need the directed scenarios: the exact saturation values, the signed-versus-unsigned choice in the minimum, greater-than against equality, wrap isolation at every lane size, and the precedence of modifier bit 1 over bit 2.

// File: rtl/lane_alu_pkg.sv
package lane_alu_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_MIN = 2'd1,
        OP_CMP = 2'd2,
        OP_RSV = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } size_e;

    // modifier bit positions
    localparam int unsigned MOD_SCALAR = 0;
    localparam int unsigned MOD_SEL1   = 1;
    localparam int unsigned MOD_SEL2   = 2;
    localparam int unsigned MOD_W      = 3;

    localparam int unsigned NUM_SIZES  = 4;
    localparam int unsigned BASE_LANE  = 8;

    typedef struct packed {
        op_e              op;
        size_e            size;
        logic [MOD_W-1:0] ext;
    } ctrl_t;

    // lane width in bits for size index k
    function automatic int unsigned lane_bits(input int unsigned k);
        return BASE_LANE << k;
    endfunction

endpackage

// File: rtl/lane_unit.sv
module lane_unit
    import lane_alu_pkg::*;
#(
    parameter int unsigned LW = 8
) (
    input  op_e              op,
    input  logic [MOD_W-1:0] ext,
    input  logic [LW-1:0]    a,
    input  logic [LW-1:0]    b,
    input  logic [LW-1:0]    old,
    output logic [LW-1:0]    res
);
    localparam logic [LW-1:0] MAX_POS = {1'b0, {(LW-1){1'b1}}};
    localparam logic [LW-1:0] MIN_NEG = {1'b1, {(LW-1){1'b0}}};
    localparam logic [LW-1:0] ONES    = {LW{1'b1}};

    logic [LW:0]   wide_sum;
    logic [LW-1:0] wrap_sum;
    logic          carry_out;
    logic          s_ovf;
    logic [LW-1:0] add_res;
    logic          a_lt_b;
    logic [LW-1:0] min_res;
    logic          cmp_true;
    logic [LW-1:0] cmp_res;

    always_comb begin
        wide_sum  = {1'b0, a} + {1'b0, b};
        wrap_sum  = wide_sum[LW-1:0];
        carry_out = wide_sum[LW];
        s_ovf     = (a[LW-1] == b[LW-1]) && (wrap_sum[LW-1] != a[LW-1]);

        if (ext[MOD_SEL1]) begin
            add_res = carry_out ? ONES : wrap_sum;
        end else if (ext[MOD_SEL2]) begin
            if (s_ovf)
                add_res = wrap_sum[LW-1] ? MAX_POS : MIN_NEG;
            else
                add_res = wrap_sum;
        end else begin
            add_res = wrap_sum;
        end
    end

    always_comb begin
        if (ext[MOD_SEL1])
            a_lt_b = $signed(a) < $signed(b);
        else
            a_lt_b = a < b;
        min_res = a_lt_b ? a : b;
    end

    always_comb begin
        if (ext[MOD_SEL1])
            cmp_true = $signed(a) > $signed(b);
        else
            cmp_true = (a == b);
        cmp_res = cmp_true ? ONES : '0;
    end

    always_comb begin
        unique case (op)
            OP_ADD:  res = add_res;
            OP_MIN:  res = min_res;
            OP_CMP:  res = cmp_res;
            default: res = old;
        endcase
    end

endmodule

// File: rtl/width_slice.sv
module width_slice
    import lane_alu_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned LW     = 8
) (
    input  op_e               op,
    input  logic [MOD_W-1:0]  ext,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] old,
    output logic [DATA_W-1:0] res
);
    localparam int unsigned NL = DATA_W / LW;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        logic [LW-1:0] lane_res;

        lane_unit #(.LW(LW)) u_lane (
            .op  (op),
            .ext (ext),
            .a   (a[i*LW +: LW]),
            .b   (b[i*LW +: LW]),
            .old (old[i*LW +: LW]),
            .res (lane_res)
        );

        if (i == 0) begin : g_low
            assign res[i*LW +: LW] = lane_res;
        end else begin : g_high
            // scalar mode leaves upper lanes at the previous destination
            assign res[i*LW +: LW] = ext[MOD_SCALAR] ? old[i*LW +: LW] : lane_res;
        end
    end

    if (NL * LW < DATA_W) begin : g_tail
        assign res[DATA_W-1:NL*LW] = old[DATA_W-1:NL*LW];
    end

endmodule

// File: rtl/packed_lane_alu.sv
module packed_lane_alu
    import lane_alu_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        in_op,
    input  logic [1:0]        in_size,
    input  logic [2:0]        in_ext,
    input  logic [DATA_W-1:0] in_src_a,
    input  logic [DATA_W-1:0] in_src_b,
    input  logic [DATA_W-1:0] in_old,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result
);
    localparam int unsigned HALF = DATA_W / 2;

    ctrl_t             ctrl;
    logic [DATA_W-1:0] by_size [NUM_SIZES];
    logic [DATA_W-1:0] comb_res;
    logic              vld_q;
    logic [DATA_W-1:0] res_q;

    assign ctrl.op   = op_e'(in_op);
    assign ctrl.size = size_e'(in_size);
    assign ctrl.ext  = in_ext;

    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
        localparam int unsigned LW = lane_bits(k);
        if (LW <= DATA_W) begin : g_fit
            width_slice #(.DATA_W(DATA_W), .LW(LW)) u_slice (
                .op  (ctrl.op),
                .ext (ctrl.ext),
                .a   (in_src_a),
                .b   (in_src_b),
                .old (in_old),
                .res (by_size[k])
            );
        end else begin : g_none
            assign by_size[k] = in_old;
        end
    end

    assign comb_res = by_size[ctrl.size];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid)
                res_q <= comb_res;
        end
    end

    assign out_valid  = vld_q;
    assign out_result = res_q;

    // R9: valid follows the request by one cycle
    a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R9: without a request the strobe drops and the result holds
    a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_result)));

    // R1: reserved opcode returns the previous destination
    a_r1_reserved_passthrough: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'd3) |=> out_result == $past(in_old));

    // R8: scalar mode on narrow lanes keeps the upper half
    a_r8_scalar_keeps_upper: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ext[MOD_SCALAR] && in_size != 2'd3)
        |=> out_result[DATA_W-1:HALF] == $past(in_old[DATA_W-1:HALF]));

    // R7: a full-width compare gives a whole-word mask
    a_r7_mask_whole: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'd2 && in_size == 2'd3)
        |=> (out_result == '0 || out_result == {DATA_W{1'b1}}));

    // R4: unsigned saturation never falls below the first operand
    a_r4_usat_not_below: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'd0 && in_size == 2'd3 && in_ext[MOD_SEL1])
        |=> out_result >= $past(in_src_a));

endmodule

// File: tb/packed_lane_alu_test.sv
module packed_lane_alu_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  in_op = 2'd0;
    logic [1:0]  in_size = 2'd0;
    logic [2:0]  in_ext = 3'd0;
    logic [63:0] in_src_a = '0;
    logic [63:0] in_src_b = '0;
    logic [63:0] in_old = '0;
    logic        out_valid;
    logic [63:0] out_result;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    packed_lane_alu uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_size(in_size), .in_ext(in_ext), .in_src_a(in_src_a),
        .in_src_b(in_src_b), .in_old(in_old), .out_valid(out_valid),
        .out_result(out_result)
    );

    task automatic check(input string req, input logic [63:0] got,
                         input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    // issue one request, check it one clock later
    task automatic run_op(input string req, input logic [1:0] op,
                          input logic [1:0] sz, input logic [2:0] ext,
                          input logic [63:0] a, input logic [63:0] b,
                          input logic [63:0] old, input logic [63:0] exp);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_size = sz; in_ext = ext;
        in_src_a = a; in_src_b = b; in_old = old;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, {63'd0, out_valid}, 64'd1);
        check(req, out_result, exp);
    endtask

    task automatic t_reset();
        check("R9 reset valid", {63'd0, out_valid}, 64'd0);
        check("R9 reset result", out_result, 64'd0);
    endtask

    task automatic t_wrap();
        run_op("R3 wrap bytes", 2'd0, 2'd0, 3'b000,
               64'hFF01_7F80_0000_0102, 64'h0101_0180_0000_0304,
               64'h0, 64'h0002_8000_0000_0406);
        run_op("R2 same words 64-bit lane", 2'd0, 2'd3, 3'b000,
               64'hFF01_7F80_0000_0102, 64'h0101_0180_0000_0304,
               64'h0, 64'h0002_8100_0000_0406);
    endtask

    task automatic t_usat();
        run_op("R4 unsigned sat 16", 2'd0, 2'd1, 3'b010,
               64'hFFF0_0001_8000_1234, 64'h0020_0002_8000_0001,
               64'h0, 64'hFFFF_0003_FFFF_1235);
        run_op("R4 bit1 over bit2", 2'd0, 2'd0, 3'b110,
               64'h7F80_01FF_40C0_0000, 64'h01FF_7FFF_40C0_0000,
               64'h0, 64'h80FF_80FF_80FF_0000);
    endtask

    task automatic t_ssat();
        run_op("R5 signed sat bytes", 2'd0, 2'd0, 3'b100,
               64'h7F80_01FF_40C0_0000, 64'h01FF_7FFF_40C0_0000,
               64'h0, 64'h7F80_7FFE_7F80_0000);
    endtask

    task automatic t_min();
        run_op("R6 unsigned min 32", 2'd1, 2'd2, 3'b000,
               64'h8000_0000_0000_0005, 64'h0000_0001_0000_0005,
               64'h0, 64'h0000_0001_0000_0005);
        run_op("R6 signed min 32", 2'd1, 2'd2, 3'b010,
               64'h8000_0000_0000_0005, 64'h0000_0001_0000_0005,
               64'h0, 64'h8000_0000_0000_0005);
    endtask

    task automatic t_cmp();
        run_op("R7 equality 16", 2'd2, 2'd1, 3'b000,
               64'h1234_8000_0000_FFFF, 64'h1234_7FFF_0001_FFFF,
               64'h0, 64'hFFFF_0000_0000_FFFF);
        run_op("R7 signed greater 16", 2'd2, 2'd1, 3'b010,
               64'h0005_8000_7FFF_FFFF, 64'h0004_7FFF_8000_0000,
               64'h0, 64'hFFFF_0000_FFFF_0000);
    endtask

    task automatic t_scalar();
        run_op("R8 scalar add byte", 2'd0, 2'd0, 3'b001,
               64'h1111_1111_1111_1101, 64'h2222_2222_2222_2202,
               64'hDEAD_BEEF_CAFE_F00D, 64'hDEAD_BEEF_CAFE_F003);
        run_op("R8 scalar full lane", 2'd0, 2'd3, 3'b001,
               64'h1111_1111_1111_1101, 64'h2222_2222_2222_2202,
               64'hDEAD_BEEF_CAFE_F00D, 64'h3333_3333_3333_3303);
        run_op("R8 scalar signed min 32", 2'd1, 2'd2, 3'b011,
               64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001,
               64'hAAAA_BBBB_CCCC_DDDD, 64'hAAAA_BBBB_FFFF_FFFF);
    endtask

    task automatic t_reserved();
        run_op("R1 reserved passthrough", 2'd3, 2'd0, 3'b110,
               64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF,
               64'h5A5A_A5A5_0F0F_F0F0, 64'h5A5A_A5A5_0F0F_F0F0);
    endtask

    task automatic t_idle();
        logic [63:0] held;
        held = out_result;
        @(negedge clk);
        in_op = 2'd0; in_size = 2'd3; in_ext = 3'b000;
        in_src_a = 64'h1; in_src_b = 64'h1; in_old = 64'h0;
        @(negedge clk);
        check("R9 idle valid low", {63'd0, out_valid}, 64'd0);
        check("R9 idle result held", out_result, held);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_wrap();
        t_usat();
        t_ssat();
        t_min();
        t_cmp();
        t_scalar();
        t_reserved();
        t_idle();
        done = 1'b1;
    end

    initial begin
        for (int n = 0; n < 5000; n++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired got 0 expected 1");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule